// File: doc/BRIEF.md
# Event-to-Interrupt Aggregator

This block receives a stream of event messages, each tagged with a global event index. It settles every message in one of three ways. If the index has a valid mapping, the event sets one status bit in one virtual interrupt (vint). If it has no mapping but has a valid re-route entry, the event goes back out as a fresh global event. If it has neither, the event is dropped and counted.

Each vint holds a bank of status bits and a per-bit enable mask. Together they drive one interrupt line toward a host interrupt controller. A configuration agent, separate from the event sources, uses a single write port to program the mapping table, the re-route table, the enable masks and the write-one-to-clear status clears. A combinational status read port lets software see the bits it is about to clear.

The event input and the outgoing global event port both use valid/ready handshakes. Only events on the re-route path can be stalled, and only by the outgoing port.

Top module: `evagg_top`

## Requirements
- R1: An accepted event whose mapping entry is valid sets status bit `bitpos` of vint `vint` at the next clock edge. After that edge, `stat_data` for `stat_sel` equal to that vint shows the bit as 1. `stat_data` reads zero for a `stat_sel` at or beyond the vint count.
- R2: `irq[v]` is 1 exactly when vint `v` has at least one status bit that is both set and enabled in its mask. Masks reset to all zero.
- R3: An event that targets a status bit that is already set leaves every status bit unchanged. No occurrence count is kept.
- R4: A configuration write with `cfg_tgt`=3 to vint `cfg_addr` clears exactly the status bits that are 1 in `cfg_wdata` and leaves the rest unchanged.
- R5: When an accepted mapped event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: An accepted event with an invalid mapping entry and a valid re-route entry raises `gev_valid` at the next edge, with `gev_idx` taken from the entry. Both hold until a cycle with `gev_ready`=1. A valid mapping entry takes priority over the re-route entry.
- R7: `evt_ready` is 0 only while the presented event is on the re-route path, `gev_valid` is 1 and `gev_ready` is 0. Mapped and dropped events are always accepted.
- R8: An accepted event whose mapping and re-route entries are both invalid produces no status change and no outgoing event. It increments `err_count` by one, and the count saturates at its maximum.
- R9: Configuration encodings. For `cfg_tgt`=0 (mapping entry `cfg_addr`), `cfg_wdata` bit 31 is the valid flag, bits 21:16 are the bit position and bits 2:0 are the vint number. For `cfg_tgt`=1 (re-route entry `cfg_addr`), bit 31 is the valid flag and bits 15:0 are the outgoing index. For `cfg_tgt`=2, `cfg_wdata` replaces the enable mask of vint `cfg_addr`. A lookup in the same cycle as a table write uses the old entry.
- R10: After reset, all table entries are invalid, all status bits and masks are zero, `gev_valid` is 0, `err_count` is 0 and `irq` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Incoming event present |
| evt_idx | input | EVT_W | Global index of incoming event |
| evt_ready | output | 1 | Incoming event accepted this cycle |
| gev_valid | output | 1 | Outgoing re-routed event present |
| gev_idx | output | GEV_W | Index of outgoing event |
| gev_ready | input | 1 | Downstream takes outgoing event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 2 | Write target: 0 map, 1 re-route, 2 mask, 3 clear |
| cfg_addr | input | EVT_W | Table entry or vint number |
| cfg_wdata | input | VINT_BITS | Write data |
| irq | output | NUM_VINT | One interrupt line per vint |
| stat_sel | input | VI_W | vint selected for status read |
| stat_data | output | VINT_BITS | Status bits of selected vint |
| err_count | output | CNT_W | Dropped-event count, saturating |

## Verification
Two pairs of functions can meet in one cycle. A mapped event and a status clear can strike the same bit, and a table write can land on the entry that an event is looking up. The bench provokes both, first with directed steps that aim an event at a bit while clearing it, and then with random stimulus over a small index range so that writes, clears and events collide often. A reference model in the bench, which applies clear before set and looks up before writing, judges every cycle's status, interrupt lines, outgoing events and ready signal.

// File: rtl/evagg_pkg.sv
package evagg_pkg;
    typedef enum logic [1:0] {
        CFG_MAP   = 2'd0,
        CFG_REMAP = 2'd1,
        CFG_MASK  = 2'd2,
        CFG_CLR   = 2'd3
    } cfg_tgt_e;

    typedef enum logic [1:0] {
        ROUTE_LOCAL = 2'd0,
        ROUTE_OUT   = 2'd1,
        ROUTE_DROP  = 2'd2
    } route_e;

    localparam int VLD_POS    = 31;
    localparam int BITPOS_LSB = 16;
endpackage

// File: rtl/evagg_tables.sv
module evagg_tables
    import evagg_pkg::*;
#(
    parameter int EVT_W = 10,
    parameter int VI_W  = 3,
    parameter int BP_W  = 6,
    parameter int GEV_W = 16,
    parameter int DW    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_map,
    input  logic             wr_remap,
    input  logic [EVT_W-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [EVT_W-1:0] rd_idx,
    output logic             map_vld,
    output logic [VI_W-1:0]  map_vint,
    output logic [BP_W-1:0]  map_bit,
    output logic             rem_vld,
    output logic [GEV_W-1:0] rem_gev
);
    localparam int DEPTH = 1 << EVT_W;

    typedef struct packed {
        logic            vld;
        logic [VI_W-1:0] vint;
        logic [BP_W-1:0] bitpos;
    } map_ent_t;

    typedef struct packed {
        logic             vld;
        logic [GEV_W-1:0] gev;
    } rem_ent_t;

    typedef struct packed {
        map_ent_t [DEPTH-1:0] map;
        rem_ent_t [DEPTH-1:0] rem;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_map) begin
            tbl_d.map[wr_addr].vld    = wr_data[VLD_POS];
            tbl_d.map[wr_addr].vint   = wr_data[VI_W-1:0];
            tbl_d.map[wr_addr].bitpos = wr_data[BITPOS_LSB +: BP_W];
        end
        if (wr_remap) begin
            tbl_d.rem[wr_addr].vld = wr_data[VLD_POS];
            tbl_d.rem[wr_addr].gev = wr_data[GEV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // Lookups read registered contents, so a same-cycle write is seen next cycle.
    assign map_vld  = tbl_q.map[rd_idx].vld;
    assign map_vint = tbl_q.map[rd_idx].vint;
    assign map_bit  = tbl_q.map[rd_idx].bitpos;
    assign rem_vld  = tbl_q.rem[rd_idx].vld;
    assign rem_gev  = tbl_q.rem[rd_idx].gev;
endmodule

// File: rtl/evagg_router.sv
module evagg_router
    import evagg_pkg::*;
#(
    parameter int GEV_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic             map_vld,
    input  logic             rem_vld,
    input  logic [GEV_W-1:0] rem_gev,
    input  logic             gev_ready,
    output logic             evt_ready,
    output logic             fire_local,
    output logic             gev_valid,
    output logic [GEV_W-1:0] gev_idx,
    output logic [CNT_W-1:0] err_count
);
    typedef struct packed {
        logic             gv;
        logic [GEV_W-1:0] gi;
        logic [CNT_W-1:0] err;
    } rt_st_t;

    rt_st_t st_d, st_q;
    route_e route;
    logic   out_free;
    logic   fire;

    always_comb begin
        if (map_vld)      route = ROUTE_LOCAL;
        else if (rem_vld) route = ROUTE_OUT;
        else              route = ROUTE_DROP;

        out_free   = !st_q.gv || gev_ready;
        evt_ready  = (route != ROUTE_OUT) || out_free;
        fire       = evt_valid && evt_ready;
        fire_local = fire && (route == ROUTE_LOCAL);

        st_d = st_q;
        if (fire && route == ROUTE_OUT) begin
            st_d.gv = 1'b1;
            st_d.gi = rem_gev;
        end else if (gev_ready) begin
            st_d.gv = 1'b0;
        end
        if (fire && route == ROUTE_DROP && st_q.err != '1) begin
            st_d.err = st_q.err + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gev_valid = st_q.gv;
    assign gev_idx   = st_q.gi;
    assign err_count = st_q.err;
endmodule

// File: rtl/evagg_vint_bank.sv
module evagg_vint_bank #(
    parameter int NUM_VINT  = 8,
    parameter int VINT_BITS = 64,
    parameter int VI_W      = 3,
    parameter int BP_W      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [VI_W-1:0]      set_vint,
    input  logic [BP_W-1:0]      set_bit,
    input  logic                 mask_we,
    input  logic                 clr_we,
    input  logic [VI_W-1:0]      reg_vint,
    input  logic [VINT_BITS-1:0] reg_data,
    input  logic [VI_W-1:0]      stat_sel,
    output logic [NUM_VINT-1:0]  irq,
    output logic [VINT_BITS-1:0] stat_data
);
    typedef struct packed {
        logic [VINT_BITS-1:0] status;
        logic [VINT_BITS-1:0] mask;
    } vint_st_t;

    logic [VINT_BITS-1:0] stat_arr [NUM_VINT];

    for (genvar g = 0; g < NUM_VINT; g++) begin : g_vint
        vint_st_t             vs_d, vs_q;
        logic                 hit_set;
        logic                 hit_reg;
        logic [VINT_BITS-1:0] set_vec;

        always_comb begin
            hit_set = set_en && (set_vint == VI_W'(g));
            hit_reg = (reg_vint == VI_W'(g));
            set_vec = hit_set ? (VINT_BITS'(1) << set_bit) : '0;

            vs_d = vs_q;
            if (clr_we && hit_reg) vs_d.status = vs_q.status & ~reg_data;
            // Set applied after clear: an arriving event wins over a clear.
            vs_d.status = vs_d.status | set_vec;
            if (mask_we && hit_reg) vs_d.mask = reg_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vs_q <= '0;
            else        vs_q <= vs_d;
        end

        assign irq[g]      = |(vs_q.status & vs_q.mask);
        assign stat_arr[g] = vs_q.status;
    end

    always_comb begin
        stat_data = '0;
        for (int i = 0; i < NUM_VINT; i++) begin
            if (stat_sel == VI_W'(i)) stat_data = stat_arr[i];
        end
    end
endmodule

// File: rtl/evagg_top.sv
module evagg_top
    import evagg_pkg::*;
#(
    parameter int NUM_VINT  = 8,
    parameter int EVT_W     = 10,
    parameter int VINT_BITS = 64,
    parameter int GEV_W     = 16,
    parameter int CNT_W     = 16,
    localparam int VI_W     = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1,
    localparam int BP_W     = (VINT_BITS > 1) ? $clog2(VINT_BITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [EVT_W-1:0]     evt_idx,
    output logic                 evt_ready,
    output logic                 gev_valid,
    output logic [GEV_W-1:0]     gev_idx,
    input  logic                 gev_ready,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_tgt,
    input  logic [EVT_W-1:0]     cfg_addr,
    input  logic [VINT_BITS-1:0] cfg_wdata,
    output logic [NUM_VINT-1:0]  irq,
    input  logic [VI_W-1:0]      stat_sel,
    output logic [VINT_BITS-1:0] stat_data,
    output logic [CNT_W-1:0]     err_count
);
    logic             map_vld;
    logic [VI_W-1:0]  map_vint;
    logic [BP_W-1:0]  map_bit;
    logic             rem_vld;
    logic [GEV_W-1:0] rem_gev;
    logic             fire_local;
    logic             addr_is_vint;
    logic             wr_map, wr_remap, wr_mask, wr_clr;

    always_comb begin
        addr_is_vint = (32'(cfg_addr) < NUM_VINT);
        wr_map   = cfg_we && (cfg_tgt == CFG_MAP);
        wr_remap = cfg_we && (cfg_tgt == CFG_REMAP);
        wr_mask  = cfg_we && (cfg_tgt == CFG_MASK) && addr_is_vint;
        wr_clr   = cfg_we && (cfg_tgt == CFG_CLR)  && addr_is_vint;
    end

    evagg_tables #(
        .EVT_W(EVT_W), .VI_W(VI_W), .BP_W(BP_W), .GEV_W(GEV_W), .DW(VINT_BITS)
    ) tables_i (
        .clk(clk), .rst_n(rst_n),
        .wr_map(wr_map), .wr_remap(wr_remap),
        .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .rd_idx(evt_idx),
        .map_vld(map_vld), .map_vint(map_vint), .map_bit(map_bit),
        .rem_vld(rem_vld), .rem_gev(rem_gev)
    );

    evagg_router #(
        .GEV_W(GEV_W), .CNT_W(CNT_W)
    ) router_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid),
        .map_vld(map_vld), .rem_vld(rem_vld), .rem_gev(rem_gev),
        .gev_ready(gev_ready),
        .evt_ready(evt_ready), .fire_local(fire_local),
        .gev_valid(gev_valid), .gev_idx(gev_idx),
        .err_count(err_count)
    );

    evagg_vint_bank #(
        .NUM_VINT(NUM_VINT), .VINT_BITS(VINT_BITS), .VI_W(VI_W), .BP_W(BP_W)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(fire_local), .set_vint(map_vint), .set_bit(map_bit),
        .mask_we(wr_mask), .clr_we(wr_clr),
        .reg_vint(cfg_addr[VI_W-1:0]), .reg_data(cfg_wdata),
        .stat_sel(stat_sel),
        .irq(irq), .stat_data(stat_data)
    );
endmodule

// File: rtl/evagg_chk.sv
module evagg_chk #(
    parameter int NUM_VINT  = 8,
    parameter int VINT_BITS = 64,
    parameter int GEV_W     = 16,
    parameter int CNT_W     = 16,
    parameter int VI_W      = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 evt_valid,
    input logic                 evt_ready,
    input logic                 gev_valid,
    input logic [GEV_W-1:0]     gev_idx,
    input logic                 gev_ready,
    input logic                 cfg_we,
    input logic [VI_W-1:0]      stat_sel,
    input logic [VINT_BITS-1:0] stat_data,
    input logic [CNT_W-1:0]     err_count
);
    // R6: a pending outgoing event stays put until taken.
    p_gev_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gev_valid && !gev_ready |=> gev_valid && $stable(gev_idx));

    // R6: no outgoing event appears without an incoming one.
    p_gev_no_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gev_valid && !evt_valid |=> !gev_valid);

    // R7: stalls happen only under output backpressure.
    p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |-> gev_valid && !gev_ready);

    // R8: the drop counter never moves backwards.
    p_err_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> err_count >= $past(err_count));

    // R8: the drop counter moves only for incoming events.
    p_err_needs_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> $stable(err_count));

    // R1: status stays still without events or configuration writes.
    p_status_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid && !cfg_we ##1 $stable(stat_sel) |-> $stable(stat_data));
endmodule

bind evagg_top evagg_chk #(
    .NUM_VINT(NUM_VINT), .VINT_BITS(VINT_BITS), .GEV_W(GEV_W),
    .CNT_W(CNT_W), .VI_W(VI_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .gev_valid(gev_valid), .gev_idx(gev_idx), .gev_ready(gev_ready),
    .cfg_we(cfg_we), .stat_sel(stat_sel), .stat_data(stat_data),
    .err_count(err_count)
);

// File: tb/evagg_top_tb_top.sv
`timescale 1ns/1ps
module evagg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [9:0]  evt_idx = '0;
    logic        evt_ready;
    logic        gev_valid;
    logic [15:0] gev_idx;
    logic        gev_ready = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_tgt = '0;
    logic [9:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [7:0]  irq;
    logic [2:0]  stat_sel = '0;
    logic [63:0] stat_data;
    logic [15:0] err_count;

    evagg_top dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
        .evt_ready(evt_ready), .gev_valid(gev_valid), .gev_idx(gev_idx),
        .gev_ready(gev_ready), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq(irq),
        .stat_sel(stat_sel), .stat_data(stat_data), .err_count(err_count)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic        m_mv [1024];
    logic [2:0]  m_mvi [1024];
    logic [5:0]  m_mb [1024];
    logic        m_uv [1024];
    logic [15:0] m_uo [1024];
    logic [63:0] m_mask [8];
    logic [63:0] m_st [8];
    logic        m_gv = 1'b0;
    logic [15:0] m_gi = '0;
    logic [15:0] m_err = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_irq();
        logic [7:0] r;
        for (int v = 0; v < 8; v++) r[v] = |(m_st[v] & m_mask[v]);
        return r;
    endfunction

    function automatic logic [63:0] map_word(input logic v, input logic [2:0] vi, input logic [5:0] b);
        return (64'(v) << 31) | (64'(b) << 16) | 64'(vi);
    endfunction

    function automatic logic [63:0] rem_word(input logic v, input logic [15:0] o);
        return (64'(v) << 31) | 64'(o);
    endfunction

    task automatic cyc(input logic ev, input logic [9:0] ei, input logic we,
                       input logic [1:0] tg, input logic [9:0] ad, input logic [63:0] wd,
                       input logic gr, input logic [2:0] sel);
        int  p;
        logic rdy, fire;
        @(negedge clk);
        chk("R2 irq", 64'(irq), 64'(exp_irq()));
        chk("R6 gev_valid", 64'(gev_valid), 64'(m_gv));
        if (m_gv) chk("R6 gev_idx", 64'(gev_idx), 64'(m_gi));
        chk("R8 err_count", 64'(err_count), 64'(m_err));
        evt_valid = ev; evt_idx = ei; cfg_we = we; cfg_tgt = tg;
        cfg_addr = ad; cfg_wdata = wd; gev_ready = gr; stat_sel = sel;
        #1;
        p = m_mv[ei] ? 0 : (m_uv[ei] ? 1 : 2);
        rdy = (p != 1) || !m_gv || gr;
        chk("R7 evt_ready", 64'(evt_ready), 64'(rdy));
        chk("R1 stat_data", stat_data, m_st[sel]);
        fire = ev && rdy;
        if (fire && p == 1) begin
            m_gv = 1'b1; m_gi = m_uo[ei];
        end else if (gr) begin
            m_gv = 1'b0;
        end
        if (fire && p == 2 && m_err != 16'hffff) m_err++;
        if (we && tg == 2'd3 && ad < 10'd8) m_st[ad[2:0]] &= ~wd;
        if (fire && p == 0) m_st[m_mvi[ei]][m_mb[ei]] = 1'b1;
        if (we && tg == 2'd0) begin
            m_mv[ad] = wd[31]; m_mvi[ad] = wd[2:0]; m_mb[ad] = wd[21:16];
        end
        if (we && tg == 2'd1) begin
            m_uv[ad] = wd[31]; m_uo[ad] = wd[15:0];
        end
        if (we && tg == 2'd2 && ad < 10'd8) m_mask[ad[2:0]] = wd;
    endtask

    task automatic idle(input logic [2:0] sel, input logic gr);
        cyc(1'b0, '0, 1'b0, 2'd0, '0, '0, gr, sel);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            m_mv[i] = 0; m_mvi[i] = 0; m_mb[i] = 0; m_uv[i] = 0; m_uo[i] = 0;
        end
        for (int v = 0; v < 8; v++) begin
            m_mask[v] = '0; m_st[v] = '0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk("R10 irq", 64'(irq), 64'd0);
        chk("R10 gev_valid", 64'(gev_valid), 64'd0);
        chk("R10 err_count", 64'(err_count), 64'd0);
        chk("R10 stat_data", stat_data, 64'd0);

        // R9: mapping encoding, event 5 -> vint 2 bit 63
        cyc(1'b0, '0, 1'b1, 2'd0, 10'd5, map_word(1'b1, 3'd2, 6'd63), 1'b1, 3'd2);
        cyc(1'b0, '0, 1'b1, 2'd2, 10'd2, '1, 1'b1, 3'd2);
        cyc(1'b1, 10'd5, 1'b0, 2'd0, '0, '0, 1'b1, 3'd2);
        idle(3'd2, 1'b1);
        chk("R1 R9 bit 63 of vint 2", stat_data, 64'h8000_0000_0000_0000);
        chk("R2 irq line 2", 64'(irq), 64'h04);
        // R3: repeat event merges
        cyc(1'b1, 10'd5, 1'b0, 2'd0, '0, '0, 1'b1, 3'd2);
        idle(3'd2, 1'b1);
        chk("R3 merged event", stat_data, 64'h8000_0000_0000_0000);
        // R4: write-one-to-clear
        cyc(1'b0, '0, 1'b1, 2'd0, 10'd6, map_word(1'b1, 3'd2, 6'd0), 1'b1, 3'd2);
        cyc(1'b1, 10'd6, 1'b0, 2'd0, '0, '0, 1'b1, 3'd2);
        cyc(1'b0, '0, 1'b1, 2'd3, 10'd2, 64'h8000_0000_0000_0000, 1'b1, 3'd2);
        idle(3'd2, 1'b1);
        chk("R4 clear keeps bit 0", stat_data, 64'h1);
        // R5: event beats clear on the same bit
        cyc(1'b1, 10'd6, 1'b1, 2'd3, 10'd2, 64'h1, 1'b1, 3'd2);
        idle(3'd2, 1'b1);
        chk("R5 event wins", stat_data, 64'h1);
        // R2: mask hides the set bit
        cyc(1'b0, '0, 1'b1, 2'd2, 10'd2, 64'h2, 1'b1, 3'd2);
        idle(3'd2, 1'b1);
        chk("R2 masked off", 64'(irq), 64'h0);
        // R6: re-route entry
        cyc(1'b0, '0, 1'b1, 2'd1, 10'd9, rem_word(1'b1, 16'h1234), 1'b1, 3'd0);
        cyc(1'b1, 10'd9, 1'b0, 2'd0, '0, '0, 1'b0, 3'd0);
        idle(3'd0, 1'b0);
        chk("R6 out valid", 64'(gev_valid), 64'd1);
        chk("R6 out index", 64'(gev_idx), 64'h1234);
        // R7: second re-route stalls, mapped passes
        cyc(1'b1, 10'd9, 1'b0, 2'd0, '0, '0, 1'b0, 3'd0);
        chk("R7 stalled", 64'(evt_ready), 64'd0);
        cyc(1'b1, 10'd5, 1'b0, 2'd0, '0, '0, 1'b0, 3'd0);
        chk("R7 mapped accepted", 64'(evt_ready), 64'd1);
        idle(3'd0, 1'b1);
        idle(3'd0, 1'b1);
        // R8: drop
        cyc(1'b1, 10'd100, 1'b0, 2'd0, '0, '0, 1'b1, 3'd0);
        idle(3'd0, 1'b1);
        chk("R8 dropped count", 64'(err_count), 64'd1);
        chk("R8 no output", 64'(gev_valid), 64'd0);
        // R6/R9: mapping overrides re-route; lookup during write uses old entry
        cyc(1'b1, 10'd9, 1'b1, 2'd0, 10'd9, map_word(1'b1, 3'd0, 6'd5), 1'b1, 3'd0);
        idle(3'd0, 1'b1);
        chk("R9 old entry used", 64'(gev_valid), 64'd1);
        cyc(1'b1, 10'd9, 1'b0, 2'd0, '0, '0, 1'b1, 3'd0);
        idle(3'd0, 1'b1);
        chk("R6 map priority", stat_data, 64'h20);

        // Random phase over a small index range so operations collide
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] wd;
            logic        we;
            logic [1:0]  tg;
            logic [9:0]  ad;
            wd = {$urandom, $urandom};
            we = ($urandom % 4) == 0;
            tg = 2'($urandom);
            ad = (tg < 2) ? 10'($urandom % 16) : 10'($urandom % 9);
            cyc(($urandom % 3) != 0, 10'($urandom % 16), we, tg, ad, wd,
                ($urandom % 4) != 0, 3'($urandom));
        end
        idle(3'd0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule